// File: doc/BRIEF.md
# GPIO Pin Interrupt Detector

This block watches a bank of already-synchronised GPIO input pins and turns pin activity into interrupt events. Each pin is set up on its own to trigger on a falling edge, a rising edge, both edges, a low level or a high level. Every event is held in a sticky status register. The block raises one interrupt line whenever a held event sits on a pin that software has enabled.

Software uses a small register port with a write strobe, a read strobe, an address and a data word. Three configuration words set each pin's trigger, and a fourth word is the enable mask. The status word has no per-pin acknowledge. Reading it returns every pending event and clears them all in one go. An event that arrives in the same cycle as that read is kept for the next read. In the RTL, each pin's three configuration bits are decoded into a named trigger mode: `TRIG_FALL`, `TRIG_RISE`, `TRIG_BOTH`, `TRIG_LOW` or `TRIG_HIGH`. The pin's detector is a `unique case` over that mode.

Top module: `gpio_irq_detect`

## Requirements
- R1: After reset, every register reads zero and `irq_o` is low. Address 0 holds the level-select bits, 1 the polarity bits, 2 the both-edges bits, 3 the enable mask and 4 the status word.
- R2: A write strobe at address 0, 1, 2 or 3 stores `wdata` in that register from the next cycle. A read at the same address returns the stored value.
- R3: When a pin's level-select bit is 0 and its polarity bit is 0, a 1-to-0 change between two consecutive clock samples sets the pin's status bit.
- R4: When a pin's level-select bit is 0 and its polarity bit is 1, a 0-to-1 change between two consecutive samples sets the pin's status bit.
- R5: When a pin's level-select bit is 1, the status bit is set in every cycle in which the pin equals its polarity bit (1 means active high, 0 means active low). The both-edges bit is ignored in this mode.
- R6: When a pin's level-select bit is 0 and its both-edges bit is 1, any change between consecutive samples sets the status bit, whatever the polarity bit holds.
- R7: A read strobe at address 4 returns the current status word on `rdata` in that cycle and clears every status bit at the next clock edge. A write to address 4 has no effect.
- R8: An event detected in the same cycle as a clearing status read is still set in the status word after the clear.
- R9: `irq_o` is high exactly when at least one status bit is set and its mask bit is 1.
- R10: An edge-mode pin held at a steady value produces no further events, so its status bit stays clear after a read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe. At the status address it clears the status word |
| addr | input | ADDR_W | Register address |
| wdata | input | NPINS | Write data |
| rdata | output | NPINS | Read data for `addr`, combinational |
| pin_i | input | NPINS | Synchronised pin inputs |
| irq_o | output | 1 | Combined interrupt |

## Verification
The bench programs all eight combinations of level-select, polarity and both-edges bits onto the 32 pins. It then rotates every pin through all four transitions of two consecutive samples, and predicts each status bit from the mode rules. A design that swapped polarity in edge mode, let both-edges override level mode, or compared against a stale sample would get particular pins wrong.

Further checks cover the other rules:
- An event is raised in the very cycle of a clearing read. A design that gives the clear priority loses that event.
- Pins are held steady after an edge. A design that treats edge mode as level mode keeps re-setting status.
- A write of all ones to the status address is expected to leave status unchanged.
- The interrupt line is checked under an empty mask, a mask on another pin and a matching mask.

// File: rtl/gpio_irq_pkg.sv
`timescale 1ns/1ps
package gpio_irq_pkg;

    // Register map. The offsets are the contract with software.
    localparam int REG_LVLSEL = 0;
    localparam int REG_POL    = 1;
    localparam int REG_BOTH   = 2;
    localparam int REG_MASK   = 3;
    localparam int REG_STS    = 4;

    // Trigger mode of one pin, decoded from its three configuration bits.
    typedef enum logic [2:0] {
        TRIG_FALL = 3'd0,
        TRIG_RISE = 3'd1,
        TRIG_BOTH = 3'd2,
        TRIG_LOW  = 3'd3,
        TRIG_HIGH = 3'd4
    } trig_e;

    // Level selection wins over both-edges; polarity picks the edge or the level.
    function automatic trig_e decode_trig(input logic lvl, input logic pol, input logic both);
        trig_e m;
        if (lvl)       m = pol ? TRIG_HIGH : TRIG_LOW;
        else if (both) m = TRIG_BOTH;
        else           m = pol ? TRIG_RISE : TRIG_FALL;
        return m;
    endfunction

endpackage

// File: rtl/gpio_irq_cfg_regs.sv
`timescale 1ns/1ps
module gpio_irq_cfg_regs
    import gpio_irq_pkg::*;
#(
    parameter int NPINS  = 32,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [NPINS-1:0]  wdata,
    output logic [NPINS-1:0]  lvl_q,
    output logic [NPINS-1:0]  pol_q,
    output logic [NPINS-1:0]  both_q,
    output logic [NPINS-1:0]  mask_q
);

    localparam logic [ADDR_W-1:0] A_LVL  = ADDR_W'(REG_LVLSEL);
    localparam logic [ADDR_W-1:0] A_POL  = ADDR_W'(REG_POL);
    localparam logic [ADDR_W-1:0] A_BOTH = ADDR_W'(REG_BOTH);
    localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(REG_MASK);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_q  <= '0;
            pol_q  <= '0;
            both_q <= '0;
            mask_q <= '0;
        end else if (wr_en) begin
            if (addr == A_LVL)  lvl_q  <= wdata;
            if (addr == A_POL)  pol_q  <= wdata;
            if (addr == A_BOTH) both_q <= wdata;
            if (addr == A_MASK) mask_q <= wdata;
        end
    end

endmodule

// File: rtl/gpio_irq_pin_detect.sv
`timescale 1ns/1ps
module gpio_irq_pin_detect
    import gpio_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic lvl,
    input  logic pol,
    input  logic both,
    output logic hit
);

    logic  prev_q;
    trig_e mode;

    // Sample from the previous cycle, used for edge comparison.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= pin;
    end

    assign mode = decode_trig(lvl, pol, both);

    always_comb begin
        hit = 1'b0;
        unique case (mode)
            TRIG_FALL: hit = prev_q & ~pin;
            TRIG_RISE: hit = ~prev_q & pin;
            TRIG_BOTH: hit = prev_q ^ pin;
            TRIG_LOW:  hit = ~pin;
            TRIG_HIGH: hit = pin;
            default:   hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/gpio_irq_status.sv
`timescale 1ns/1ps
module gpio_irq_status #(
    parameter int NPINS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] evt,
    input  logic             clr,
    input  logic [NPINS-1:0] mask,
    output logic [NPINS-1:0] status_q,
    output logic             irq
);

    logic [NPINS-1:0] kept;

    // A clear drops the old bits only; new events in the same cycle survive.
    assign kept = clr ? '0 : status_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= kept | evt;
    end

    assign irq = |(status_q & mask);

endmodule

// File: rtl/gpio_irq_detect.sv
`timescale 1ns/1ps
module gpio_irq_detect
    import gpio_irq_pkg::*;
#(
    parameter int NPINS  = 32,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [NPINS-1:0]  wdata,
    output logic [NPINS-1:0]  rdata,
    input  logic [NPINS-1:0]  pin_i,
    output logic              irq_o
);

    localparam logic [ADDR_W-1:0] A_STS = ADDR_W'(REG_STS);

    logic [NPINS-1:0] lvl_q, pol_q, both_q, mask_q;
    logic [NPINS-1:0] evt;
    logic [NPINS-1:0] status_q;
    logic             sts_clr;

    gpio_irq_cfg_regs #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .addr   (addr),
        .wdata  (wdata),
        .lvl_q  (lvl_q),
        .pol_q  (pol_q),
        .both_q (both_q),
        .mask_q (mask_q)
    );

    for (genvar g = 0; g < NPINS; g++) begin : g_pin
        gpio_irq_pin_detect u_det (
            .clk   (clk),
            .rst_n (rst_n),
            .pin   (pin_i[g]),
            .lvl   (lvl_q[g]),
            .pol   (pol_q[g]),
            .both  (both_q[g]),
            .hit   (evt[g])
        );
    end

    assign sts_clr = rd_en && (addr == A_STS);

    gpio_irq_status #(.NPINS(NPINS)) u_sts (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt      (evt),
        .clr      (sts_clr),
        .mask     (mask_q),
        .status_q (status_q),
        .irq      (irq_o)
    );

    always_comb begin
        case (int'(addr))
            REG_LVLSEL: rdata = lvl_q;
            REG_POL:    rdata = pol_q;
            REG_BOTH:   rdata = both_q;
            REG_MASK:   rdata = mask_q;
            REG_STS:    rdata = status_q;
            default:    rdata = '0;
        endcase
    end

endmodule

// File: rtl/gpio_irq_detect_chk.sv
`timescale 1ns/1ps
module gpio_irq_detect_chk
    import gpio_irq_pkg::*;
#(
    parameter int NPINS  = 32,
    parameter int ADDR_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              rd_en,
    input logic [ADDR_W-1:0] addr,
    input logic [NPINS-1:0]  wdata,
    input logic [NPINS-1:0]  pin_i,
    input logic              irq_o,
    input logic [NPINS-1:0]  lvl_q,
    input logic [NPINS-1:0]  pol_q,
    input logic [NPINS-1:0]  mask_q,
    input logic [NPINS-1:0]  evt,
    input logic [NPINS-1:0]  status_q
);

    localparam logic [ADDR_W-1:0] A_STS = ADDR_W'(REG_STS);
    localparam logic [ADDR_W-1:0] A_LVL = ADDR_W'(REG_LVLSEL);

    AST_CFG_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_LVL) |=> (lvl_q == $past(wdata))); // R2

    AST_LEVEL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        ((lvl_q & pol_q & pin_i) & ~evt) == '0); // R5

    AST_LEVEL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        ((lvl_q & ~pol_q & ~pin_i) & ~evt) == '0); // R5

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == A_STS) |=> ((status_q & ~$past(evt)) == '0)); // R7

    AST_STATUS_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!(rd_en && addr == A_STS) && evt == '0) |=> (status_q == $past(status_q))); // R7

    AST_EVENT_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        (evt != '0) |=> ((status_q & $past(evt)) == $past(evt))); // R8

    AST_MASK_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0) |-> !irq_o); // R9

    AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> ((status_q & mask_q) != '0)); // R9

endmodule

bind gpio_irq_detect gpio_irq_detect_chk #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .addr     (addr),
    .wdata    (wdata),
    .pin_i    (pin_i),
    .irq_o    (irq_o),
    .lvl_q    (lvl_q),
    .pol_q    (pol_q),
    .mask_q   (mask_q),
    .evt      (evt),
    .status_q (status_q)
);

// File: tb/gpio_irq_detect_bench.sv
`timescale 1ns/1ps
module gpio_irq_detect_bench;

    localparam int NPINS  = 32;
    localparam int ADDR_W = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic              rd_en = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [NPINS-1:0]  wdata = '0;
    logic [NPINS-1:0]  pin_i = '0;
    logic [NPINS-1:0]  rdata;
    logic              irq_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    gpio_irq_detect #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_gpio_irq_detect (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_en),
        .rd_en (rd_en),
        .addr  (addr),
        .wdata (wdata),
        .rdata (rdata),
        .pin_i (pin_i),
        .irq_o (irq_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [NPINS-1:0] d);
        @(negedge clk);
        addr = ADDR_W'(a); wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a, output logic [NPINS-1:0] d, output logic irq);
        @(negedge clk);
        addr = ADDR_W'(a); rd_en = 1'b1;
        #1 d = rdata; irq = irq_o;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    function automatic bit level_hit(bit t, bit v, bit x);
        return t && (v ? x : !x);
    endfunction

    function automatic bit edge_hit(bit t, bit v, bit a, bit p, bit c);
        if (t)      return v ? c : !c;
        else if (a) return p != c;
        else if (v) return !p && c;
        else        return p && !c;
    endfunction

    initial begin
        logic [NPINS-1:0] d, d2, tcfg, vcfg, acfg, prevv, curv, expv, exp2;
        logic irq, irq2;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values
        for (int a = 0; a < 5; a++) begin
            rd(a, d, irq);
            check("R1", d, 32'h0);
        end
        check("R1 irq", {31'b0, irq_o}, 32'h0);

        // R2: configuration read-back
        wr(0, 32'hA5A5_0F0F); rd(0, d, irq); check("R2 lvl", d, 32'hA5A5_0F0F);
        wr(1, 32'h1234_5678); rd(1, d, irq); check("R2 pol", d, 32'h1234_5678);
        wr(2, 32'hFFFF_0000); rd(2, d, irq); check("R2 both", d, 32'hFFFF_0000);
        wr(3, 32'h8000_0001); rd(3, d, irq); check("R2 mask", d, 32'h8000_0001);

        // Sweep: pin i gets mode code i%8 and transition ((i/8)+k)%4
        for (int i = 0; i < NPINS; i++) begin
            tcfg[i] = (i % 8) >= 4;
            vcfg[i] = ((i % 8) / 2) % 2 == 1;
            acfg[i] = (i % 2) == 1;
        end
        wr(0, tcfg); wr(1, vcfg); wr(2, acfg); wr(3, '1);
        for (int k = 0; k < 4; k++) begin
            for (int i = 0; i < NPINS; i++) begin
                int tr;
                tr = ((i / 8) + k) % 4;
                prevv[i] = tr >= 2;
                curv[i]  = (tr % 2) == 1;
            end
            @(negedge clk); pin_i = prevv;
            repeat (2) @(negedge clk);
            rd(4, d, irq);
            pin_i = curv;
            rd(4, d, irq);
            for (int i = 0; i < NPINS; i++) begin
                expv[i] = level_hit(tcfg[i], vcfg[i], prevv[i]) |
                          edge_hit(tcfg[i], vcfg[i], acfg[i], prevv[i], curv[i]);
                exp2[i] = level_hit(tcfg[i], vcfg[i], curv[i]);
                if (tcfg[i])      check("R5 pin", {31'b0, d[i]}, {31'b0, expv[i]});
                else if (acfg[i]) check("R6 pin", {31'b0, d[i]}, {31'b0, expv[i]});
                else if (vcfg[i]) check("R4 pin", {31'b0, d[i]}, {31'b0, expv[i]});
                else              check("R3 pin", {31'b0, d[i]}, {31'b0, expv[i]});
            end
            check("R9 sweep irq", {31'b0, irq}, {31'b0, |expv});
            rd(4, d2, irq2);
            check("R7 R10 after clear", d2, exp2);
        end

        // Reconfigure: all pins rising edge, mask off
        wr(0, '0); wr(2, '0); wr(1, '1); wr(3, '0);
        @(negedge clk); pin_i = '0;
        repeat (2) @(negedge clk);
        rd(4, d, irq); rd(4, d, irq);
        check("R10 quiet", d, 32'h0);

        // R8: event in the same cycle as the clearing read
        @(negedge clk);
        addr = ADDR_W'(4); rd_en = 1'b1; pin_i[0] = 1'b1;
        #1 d = rdata;
        check("R8 before", d, 32'h0);
        @(negedge clk); rd_en = 1'b0;
        rd(4, d, irq);
        check("R8 kept", d, 32'h1);

        // R9: mask gating
        @(negedge clk); pin_i[3] = 1'b1;
        repeat (2) @(negedge clk);
        check("R9 mask zero", {31'b0, irq_o}, 32'h0);
        wr(3, 32'h20);
        #1 check("R9 other mask", {31'b0, irq_o}, 32'h0);
        wr(3, 32'h08);
        #1 check("R9 match", {31'b0, irq_o}, 32'h1);

        // R7: writes to status ignored
        wr(4, '0);
        rd(4, d, irq);
        check("R7 write zero ignored", d, 32'h8);
        wr(4, '1);
        rd(4, d, irq);
        check("R7 write ones ignored", d, 32'h0);
        check("R10 held high", {31'b0, irq_o}, 32'h0);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule